// File: doc/BRIEF.md
# Multi-Format Conversion Result Output Port

This block holds one 18-bit conversion result and presents it to a host in one of four formats, chosen by a 2-bit mode input. Three formats are parallel buses of different widths that share the same output lines: a full 18-bit bus, a 16-bit word bus with a selectable slice, and a byte bus with a selectable slice. The fourth format is a serial stream. In that format the block either generates the serial clock itself or follows a clock supplied by the host.

A result-valid strobe captures a new result. Parallel reads are gated by active-low chip-select and read strobes. In every format except the full 18-bit one, a coding input chooses between straight binary and twos complement. Twos complement is obtained by inverting the MSB. In the narrower formats, slice-select inputs choose which part of the result appears on the bus. Lines that carry no data are driven to zero.

Top module: `adc_result_port`

## Requirements
- R1: Mode encoding is 00 full 18-bit parallel, 01 16-bit word, 10 byte, 11 serial. In mode 00, par_data equals the stored result on all 18 lines in straight binary, whatever the value of code_bin.
- R2: In modes 01, 10 and 11, code_bin high gives straight binary. code_bin low inverts the result MSB, giving twos complement, before any slicing or shifting.
- R3: In mode 01 the word bus is par_data[17:2] and par_data[1:0] is zero. With fmt_a0 low, par_data[17:2] carries result bits 17..2. With fmt_a0 high, par_data[3:2] carries result bits 1..0 and par_data[17:4] is zero.
- R4: In mode 10 the byte bus is par_data[17:10] and par_data[9:0] is zero. {fmt_a1,fmt_a0} = 00 selects result bits 17..10, 01 selects bits 9..2, and 10 or 11 places bits 1..0 on par_data[11:10] with par_data[17:12] zero.
- R5: par_oe is high exactly while cs_n and rd_n are both low and mode is not 11. par_data takes the formatted value at each clock edge where par_oe is high and otherwise holds its value.
- R6: The stored result is loaded on each clock edge with result_valid high. A read at that same edge presents the previous result, and the new result appears from the next read edge on.
- R7: In mode 11 with ext_clk_sel low, result_valid starts an 18-bit transfer, MSB first, on sdata. sclk_out idles low and delivers 18 rising edges. sdata changes only when sclk_out falls and is 0 once the transfer is done.
- R8: In the internal-clock serial case with after_conv high, div_sel codes 0..3 give an sclk_out period of 2, 4, 8 or 16 clock cycles. With after_conv low, the period is 2 cycles whatever div_sel holds.
- R9: In mode 11 with ext_clk_sel high, sclk_out stays low. Each falling edge of sclk_in seen while cs_n is low advances sdata by one bit, MSB first, after a synchronisation delay of three clock cycles. A falling edge while cs_n is high leaves sdata unchanged.
- R10: A result_valid strobe during a serial transfer abandons that transfer and restarts from the MSB of the new result.
- R11: In modes 00 to 10, sdata and sclk_out are 0. In mode 11, par_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| result_valid | input | 1 | Captures result_in for one clock |
| result_in | input | 18 | New conversion result |
| mode | input | 2 | Output format select |
| code_bin | input | 1 | 1 straight binary, 0 twos complement (not in mode 00) |
| fmt_a0 | input | 1 | Slice select, low bit |
| fmt_a1 | input | 1 | Slice select, high bit (byte mode) |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| ext_clk_sel | input | 1 | Serial clock source: 0 internal, 1 external |
| after_conv | input | 1 | Read-after-convert option, enables the clock divider |
| div_sel | input | 2 | Internal serial clock divide code |
| sclk_in | input | 1 | External serial clock |
| par_data | output | 18 | Parallel output lines |
| par_oe | output | 1 | Parallel drive enable |
| sdata | output | 1 | Serial data |
| sclk_out | output | 1 | Internally generated serial clock |

## Verification
Two events can fall on the same clock edge: a result_valid strobe can coincide with a parallel read edge, and it can also arrive in the middle of a serial transfer. The bench provokes the first by pulsing result_valid while cs_n and rd_n are low. It expects the old result from that read and the new one from the next read. It provokes the second by reloading partway through an internally clocked transfer with the slowest divider. It then expects 18 fresh rising edges that carry the new word from its MSB, at the unchanged period.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_WORD = 2'b01,
    MODE_BYTE = 2'b10,
    MODE_SER  = 2'b11
  } port_mode_e;
endpackage

// File: rtl/adc_port_fmt.sv
module adc_port_fmt
  import adc_port_pkg::*;
#(
  parameter int RES_W  = 18,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0] res,
  input  port_mode_e       mode,
  input  logic             code_bin,
  input  logic             sel_a0,
  input  logic             sel_a1,
  output logic [RES_W-1:0] coded,
  output logic [RES_W-1:0] bus
);
  localparam int REM_W  = RES_W - WORD_W;
  localparam int BLO    = RES_W - BYTE_W;
  localparam int TAIL_W = RES_W - 2 * BYTE_W;

  // MSB inversion gives twos complement; full mode is always straight binary
  always_comb begin
    coded = res;
    if (mode != MODE_FULL && !code_bin) coded[RES_W-1] = ~res[RES_W-1];
  end

  always_comb begin
    bus = '0;
    unique case (mode)
      MODE_FULL: bus = res;
      MODE_WORD: begin
        if (!sel_a0) bus[RES_W-1:REM_W] = coded[RES_W-1:REM_W];
        else         bus[2*REM_W-1:REM_W] = coded[REM_W-1:0];
      end
      MODE_BYTE: begin
        unique case ({sel_a1, sel_a0})
          2'b00:   bus[RES_W-1:BLO] = coded[RES_W-1 -: BYTE_W];
          2'b01:   bus[RES_W-1:BLO] = coded[RES_W-1-BYTE_W -: BYTE_W];
          default: bus[BLO +: TAIL_W] = coded[TAIL_W-1:0];
        endcase
      end
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/adc_port_sclkgen.sv
module adc_port_sclkgen #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_code,
  output logic             sclk,
  output logic             fall_tick
);
  localparam int CNT_W = (1 << DIV_W) - 1 > 0 ? (1 << DIV_W) - 1 : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic [CNT_W-1:0] half_m1;
  logic             at_end;

  // half period in system clocks is 2**div_code
  assign half_m1 = CNT_W'((1 << div_code) - 1);
  assign at_end  = (cnt_q == half_m1);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (restart || !run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (at_end) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk      = sclk_q;
  assign fall_tick = run && !restart && at_end && sclk_q;
endmodule

// File: rtl/adc_port_shifter.sv
module adc_port_shifter #(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] word,
  input  logic             advance,
  output logic             bit_out,
  output logic             active
);
  localparam int LEFT_W = $clog2(RES_W + 1);

  logic [RES_W-1:0]  sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              act_q, act_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    act_d  = act_q;
    if (load) begin
      sh_d   = word;
      left_d = LEFT_W'(RES_W);
      act_d  = 1'b1;
    end else if (act_q && advance) begin
      sh_d   = {sh_q[RES_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
      if (left_q == LEFT_W'(1)) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      act_q  <= act_d;
    end
  end

  assign bit_out = act_q & sh_q[RES_W-1];
  assign active  = act_q;
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_port_pkg::*;
#(
  parameter int RES_W  = 18,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             result_valid,
  input  logic [RES_W-1:0] result_in,
  input  logic [1:0]       mode,
  input  logic             code_bin,
  input  logic             fmt_a0,
  input  logic             fmt_a1,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             ext_clk_sel,
  input  logic             after_conv,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             sclk_in,
  output logic [RES_W-1:0] par_data,
  output logic             par_oe,
  output logic             sdata,
  output logic             sclk_out
);
  port_mode_e       mode_e;
  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] par_q, par_d;
  logic [RES_W-1:0] coded, bus;
  logic             rd_en, ser_mode, int_mode, ext_mode;
  logic [DIV_W-1:0] div_eff;
  logic             gen_sclk, gen_fall;
  logic [SYNC_N:0]  ext_sync_q;
  logic             ext_fall;
  logic             sh_load, sh_adv, sh_bit, sh_active;

  assign mode_e   = port_mode_e'(mode);
  assign ser_mode = (mode_e == MODE_SER);
  assign int_mode = ser_mode && !ext_clk_sel;
  assign ext_mode = ser_mode && ext_clk_sel;
  assign rd_en    = !cs_n && !rd_n && !ser_mode;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // result register and parallel output register
  always_comb begin
    res_d = res_q;
    par_d = par_q;
    if (result_valid) res_d = result_in;
    if (rd_en)        par_d = bus;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      res_q <= '0;
      par_q <= '0;
    end else begin
      res_q <= res_d;
      par_q <= par_d;
    end
  end

  adc_port_fmt #(.RES_W(RES_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_fmt (
    .res      (res_q),
    .mode     (mode_e),
    .code_bin (code_bin),
    .sel_a0   (fmt_a0),
    .sel_a1   (fmt_a1),
    .coded    (coded),
    .bus      (bus)
  );

  // divider honoured only for internal clock with read-after-convert
  assign div_eff = (int_mode && after_conv) ? div_sel : '0;

  adc_port_sclkgen #(.DIV_W(DIV_W)) i_sclkgen (
    .clk       (clk),
    .rst_n     (rst_i),
    .run       (int_mode && sh_active),
    .restart   (sh_load),
    .div_code  (div_eff),
    .sclk      (gen_sclk),
    .fall_tick (gen_fall)
  );

  // external clock synchroniser plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ext_sync_q <= '0;
    else        ext_sync_q <= {ext_sync_q[SYNC_N-1:0], sclk_in};
  end
  assign ext_fall = ext_sync_q[SYNC_N] && !ext_sync_q[SYNC_N-1];

  assign sh_load = result_valid && ser_mode;
  assign sh_adv  = int_mode ? gen_fall : (ext_mode && ext_fall && !cs_n);

  // the serial word takes the newly captured value when loading
  logic [RES_W-1:0] load_word;
  always_comb begin
    load_word = result_in;
    if (!code_bin) load_word[RES_W-1] = ~result_in[RES_W-1];
  end

  adc_port_shifter #(.RES_W(RES_W)) i_shifter (
    .clk     (clk),
    .rst_n   (rst_i),
    .load    (sh_load),
    .word    (load_word),
    .advance (sh_adv),
    .bit_out (sh_bit),
    .active  (sh_active)
  );

  logic unused_coded;
  assign unused_coded = ^coded;

  assign par_data = par_q;
  assign par_oe   = rd_en;
  assign sdata    = ser_mode ? sh_bit : 1'b0;
  assign sclk_out = int_mode ? gen_sclk : 1'b0;
endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk #(
  parameter int RES_W  = 18,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             ext_clk_sel,
  input logic             fmt_a0,
  input logic [RES_W-1:0] par_data,
  input logic             par_oe,
  input logic             sdata,
  input logic             sclk_out
);
  localparam int REM_W = RES_W - WORD_W;
  localparam int BLO   = RES_W - BYTE_W;

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !par_oe |=> $stable(par_data));

  assert_word_low_slice_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (par_oe && mode == 2'b01 && fmt_a0) |=>
      (par_data[RES_W-1:2*REM_W] == '0 && par_data[REM_W-1:0] == '0));

  assert_byte_lines_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_oe && mode == 2'b10) |=> par_data[BLO-1:0] == '0);

  assert_data_steady_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_out && $past(sclk_out)) |-> $stable(sdata));

  assert_clock_only_internal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_out) |-> (mode == 2'b11 && !ext_clk_sel));
endmodule

bind adc_result_port adc_result_port_chk #(
  .RES_W(RES_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .ext_clk_sel (ext_clk_sel),
  .fmt_a0      (fmt_a0),
  .par_data    (par_data),
  .par_oe      (par_oe),
  .sdata       (sdata),
  .sclk_out    (sclk_out)
);

// File: tb/test_adc_result_port.sv
module test_adc_result_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        result_valid;
  logic [17:0] result_in;
  logic [1:0]  mode;
  logic        code_bin, fmt_a0, fmt_a1, cs_n, rd_n;
  logic        ext_clk_sel, after_conv, sclk_in;
  logic [1:0]  div_sel;
  logic [17:0] par_data;
  logic        par_oe, sdata, sclk_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_port i_adc_result_port (
    .clk(clk), .rst_n(rst_n), .result_valid(result_valid), .result_in(result_in),
    .mode(mode), .code_bin(code_bin), .fmt_a0(fmt_a0), .fmt_a1(fmt_a1),
    .cs_n(cs_n), .rd_n(rd_n), .ext_clk_sel(ext_clk_sel), .after_conv(after_conv),
    .div_sel(div_sel), .sclk_in(sclk_in), .par_data(par_data), .par_oe(par_oe),
    .sdata(sdata), .sclk_out(sclk_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  function automatic logic [17:0] exp_par(logic [17:0] r, logic [1:0] m, logic b, logic a0, logic a1);
    logic [17:0] c;
    logic [17:0] o;
    c = r;
    o = '0;
    if (m != 2'b00 && !b) c[17] = ~c[17];
    case (m)
      2'b00: o = r;
      2'b01: if (!a0) o[17:2] = c[17:2]; else o[3:2] = c[1:0];
      2'b10: case ({a1, a0})
               2'b00:   o[17:10] = c[17:10];
               2'b01:   o[17:10] = c[9:2];
               default: o[11:10] = c[1:0];
             endcase
      default: o = '0;
    endcase
    return o;
  endfunction

  function automatic logic [17:0] ser_word(logic [17:0] r, logic b);
    return b ? r : {~r[17], r[16:0]};
  endfunction

  task automatic load(input logic [17:0] v);
    @(negedge clk);
    result_in = v; result_valid = 1'b1;
    @(negedge clk);
    result_valid = 1'b0;
  endtask

  task automatic do_read(output logic [17:0] got, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    #1 oe = par_oe;
    @(negedge clk);
    got = par_data;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic cap_int(input logic [17:0] w, input int per, input string req);
    int got = 0; int last = -1; int bad = 0; int perbad = 0; int extra = 0;
    logic prev = 1'b0;
    for (int c = 0; c < 3000 && got < 18; c++) begin
      @(negedge clk);
      if (sclk_out && !prev) begin
        if (sdata !== w[17-got]) bad++;
        if (last >= 0 && c - last != per) perbad++;
        last = c;
        got++;
      end
      prev = sclk_out;
    end
    chk(got == 18 && bad == 0, {req, " serial bits"}, bad, 0);
    chk(perbad == 0, {"R8 period ", req}, perbad, 0);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (sclk_out && !prev) extra++;
      prev = sclk_out;
    end
    chk(extra == 0 && sdata == 1'b0, "R7 idle after transfer", extra, 0);
  endtask

  initial begin
    logic [17:0] r, r2, got, e;
    logic oe;
    int unsigned seed;
    seed = $urandom(32'h0000_5eed);
    rst_n = 1'b0; result_valid = 1'b0; result_in = '0; mode = 2'b00;
    code_bin = 1'b1; fmt_a0 = 1'b0; fmt_a1 = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
    ext_clk_sel = 1'b0; after_conv = 1'b1; div_sel = 2'b00; sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(par_data == '0 && par_oe == 1'b0, "R5 reset state par", par_data, 0);
    chk(sdata == 1'b0 && sclk_out == 1'b0, "R11 reset state serial", {sdata, sclk_out}, 0);

    // directed: full mode ignores coding input
    mode = 2'b00; code_bin = 1'b0;
    load(18'h2_0001);
    do_read(got, oe);
    chk(got == 18'h2_0001 && oe, "R1 full mode straight binary", got, 18'h2_0001);

    // random parallel formats
    for (int i = 0; i < 80; i++) begin
      r = 18'($urandom());
      mode = 2'($urandom_range(0, 2));
      code_bin = 1'($urandom()); fmt_a0 = 1'($urandom()); fmt_a1 = 1'($urandom());
      load(r);
      do_read(got, oe);
      e = exp_par(r, mode, code_bin, fmt_a0, fmt_a1);
      case (mode)
        2'b00:   chk(got == e, "R1 full bus", got, e);
        2'b01:   chk(got == e, "R3 word bus R2 coding", got, e);
        default: chk(got == e, "R4 byte bus R2 coding", got, e);
      endcase
      chk(oe == 1'b1, "R5 drive enable on read", oe, 1);
      @(negedge clk);
      chk(sdata == 1'b0 && sclk_out == 1'b0, "R11 serial quiet in parallel mode", {sdata, sclk_out}, 0);
    end

    // hold: inputs change without a read
    mode = 2'b00; load(18'h1_2345); do_read(got, oe);
    @(negedge clk);
    mode = 2'b01; fmt_a0 = 1'b1; cs_n = 1'b0; rd_n = 1'b1;
    result_in = 18'h3_ffff; result_valid = 1'b1;
    #1 chk(par_oe == 1'b0, "R5 no enable with rd_n high", par_oe, 0);
    @(negedge clk);
    result_valid = 1'b0; cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk(par_data == 18'h1_2345, "R5 hold without read", par_data, 18'h1_2345);
    rd_n = 1'b1;

    // collision: result strobe on the read edge
    mode = 2'b00; load(18'h0_0abc);
    @(negedge clk);
    result_in = 18'h3_1111; result_valid = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    result_valid = 1'b0;
    chk(par_data == 18'h0_0abc, "R6 same-edge read shows previous", par_data, 18'h0_0abc);
    @(negedge clk);
    chk(par_data == 18'h3_1111, "R6 next read shows new", par_data, 18'h3_1111);
    cs_n = 1'b1; rd_n = 1'b1;

    // serial mode disables parallel drive
    mode = 2'b11; cs_n = 1'b0; rd_n = 1'b0;
    #1 chk(par_oe == 1'b0, "R11 no parallel drive in serial", par_oe, 0);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;

    // internal clock, all divide codes, both after_conv settings
    ext_clk_sel = 1'b0;
    for (int ac = 0; ac < 2; ac++) begin
      for (int d = 0; d < 4; d++) begin
        after_conv = 1'(ac); div_sel = 2'(d);
        code_bin = 1'($urandom());
        r = 18'($urandom());
        load(r);
        cap_int(ser_word(r, code_bin), ac ? (2 << d) : 2, ac ? "R7 R2" : "R8 no divide");
      end
    end

    // restart mid-transfer with the slowest divider
    after_conv = 1'b1; div_sel = 2'b11; code_bin = 1'b1;
    r = 18'h2_aaaa; r2 = 18'h1_5a5a;
    load(r);
    repeat (70) @(negedge clk);
    load(r2);
    cap_int(r2, 16, "R10 restart");

    // external clock, with an ignored edge while deselected
    ext_clk_sel = 1'b1; code_bin = 1'b0; cs_n = 1'b1;
    r = 18'h0_c3a5;
    load(r);
    e = ser_word(r, 1'b0);
    sclk_in = 1'b1; repeat (4) @(negedge clk);
    sclk_in = 1'b0; repeat (5) @(negedge clk);
    chk(sdata == e[17], "R9 fall ignored while cs_n high", sdata, e[17]);
    cs_n = 1'b0;
    begin
      int bad = 0; int rises = 0;
      for (int k = 0; k < 18; k++) begin
        @(negedge clk);
        if (sdata !== e[17-k]) bad++;
        if (sclk_out) rises++;
        sclk_in = 1'b1; repeat (4) @(negedge clk);
        sclk_in = 1'b0; repeat (4) @(negedge clk);
      end
      chk(bad == 0, "R9 external clock bits", bad, 0);
      chk(rises == 0 && sclk_out == 1'b0, "R9 no internal clock", rises, 0);
      chk(sdata == 1'b0, "R9 done after 18 falls", sdata, 0);
    end
    cs_n = 1'b1;

    done = 1;
    finish_run();
  end
endmodule